// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block serves one active-low external interrupt pin of a small microcontroller. The pin is brought into the clock domain through a synchronizer chain. A falling edge, or in level mode a low level, sets a request latch. The latch drives an interrupt request to the CPU unless the request is masked. Software sees and controls the block through one 8-bit status and control register on a simple select/write-enable register bus.

The latch is cleared in two ways: by software writing 1 to a write-only acknowledge bit, or by a one-cycle vector-fetch pulse from the CPU. While masked, the latch still records events, so software can poll the pending flag. A separate register bit drives an output that disables the pin's pullup.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, the register reads 8'h00, `irq_req` is 0 and `pullup_dis` is 0.
- R2: Register fields: bit 5 is pullup-disable (read/write), bit 3 is pending (read-only), bit 2 is acknowledge (write-only), bit 1 is mask (read/write) and bit 0 is mode (read/write, 0 = edge only, 1 = edge plus low level). Bits 7, 6, 4 and 2 always read 0.
- R3: In edge mode, a falling edge on `pin_n` sets pending. The flag reads 1 on the third rising clock edge after the pin changes. A pin that stays low after the latch is cleared does not set it again.
- R4: In level mode, while the synchronized pin is low, pending stays 1 even when acknowledged. Once the pin is high, an acknowledge clears it.
- R5: `irq_req` is 1 exactly when pending is 1 and mask is 0. While masked, events still set pending.
- R6: Writing 1 to bit 2 clears pending. Writing 0 to bit 2 leaves pending unchanged.
- R7: A write to bit 3 has no effect on pending.
- R8: A one-cycle pulse on `vec_fetch` clears pending the same way as an acknowledge.
- R9: If a falling edge sets the latch in the same cycle as an acknowledge or vector fetch, pending ends up 1.
- R10: `pullup_dis` equals register bit 5.
- R11: A rising edge on `pin_n` in edge mode does not set pending.
- R12: `csr_rdata` is 8'h00 whenever `csr_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| csr_sel | input | 1 | Register select |
| csr_we | input | 1 | Write enable, qualified by select |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, combinational while selected |
| vec_fetch | input | 1 | One-cycle vector-fetch clear pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| pullup_dis | output | 1 | High disables the pin pullup |

## Verification
A request latch stuck high would appear as a pending flag that stays at 1 after an acknowledge or vector fetch. It would also keep `irq_req` asserted, and both show up on the next read after the clear. A lost or wrongly timed edge would show up on a read on the third clock after the pin falls. Mode or mask errors would show up in the same read: pending held or dropped against the pin level, or `irq_req` disagreeing with the mask. Races between a clear and an edge are set up so that both land on the same clock edge. The read that follows then shows whether the edge won.

// File: rtl/extint_pkg.sv
package extint_pkg;
   localparam int REG_W     = 8;
   localparam int BIT_MODE  = 0;
   localparam int BIT_MASK  = 1;
   localparam int BIT_ACK   = 2;
   localparam int BIT_PEND  = 3;
   localparam int BIT_PUDIS = 5;

   typedef struct packed {
      logic pudis;
      logic mask;
      logic mode;
   } extint_cfg_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("extint_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/extint_latch.sv
module extint_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic level_mode,
   input  logic clr,
   output logic fall,
   output logic pend
);
   logic prev_s;
   logic set_req;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_s <= 1'b1;
      else        prev_s <= pin_s;

   assign fall    = prev_s & ~pin_s;
   assign set_req = fall | (level_mode & ~pin_s);

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
      else if (clr)     pend <= 1'b0;
endmodule

// File: rtl/extint_csr.sv
module extint_csr
   import extint_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [REG_W-1:0]  wdata,
   input  logic              pend,
   output logic [REG_W-1:0]  rdata,
   output extint_cfg_t       cfg,
   output logic              ack
);
   logic wr;
   assign wr  = sel & we;
   assign ack = wr & wdata[BIT_ACK];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg <= '0;
      else if (wr) begin
         cfg.pudis <= wdata[BIT_PUDIS];
         cfg.mask  <= wdata[BIT_MASK];
         cfg.mode  <= wdata[BIT_MODE];
      end

   logic [REG_W-1:0] view;
   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_view
         if (b == BIT_MODE)       begin : g_mo assign view[b] = cfg.mode;  end
         else if (b == BIT_MASK)  begin : g_ma assign view[b] = cfg.mask;  end
         else if (b == BIT_PEND)  begin : g_pe assign view[b] = pend;      end
         else if (b == BIT_PUDIS) begin : g_pu assign view[b] = cfg.pudis; end
         else                     begin : g_z  assign view[b] = 1'b0;      end
      end
   endgenerate

   assign rdata = sel ? view : '0;

   // R10
   pudis_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg.pudis) |-> $past(wr && wdata[BIT_PUDIS]));
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_n,
   input  logic       csr_sel,
   input  logic       csr_we,
   input  logic [7:0] csr_wdata,
   output logic [7:0] csr_rdata,
   input  logic       vec_fetch,
   output logic       irq_req,
   output logic       pullup_dis
);
   import extint_pkg::*;

   generate
      if (REG_W != 8) begin : g_bad_width
         $error("extint_ctrl: register must be 8 bits");
      end
   endgenerate

   logic        pin_s;
   logic        fall;
   logic        pend;
   logic        ack;
   logic        clr;
   extint_cfg_t cfg;

   extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_n), .q_sync(pin_s));

   assign clr = ack | vec_fetch;

   extint_latch u_latch (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .level_mode(cfg.mode),
      .clr(clr), .fall(fall), .pend(pend));

   extint_csr u_csr (
      .clk(clk), .rst_n(rst_n), .sel(csr_sel), .we(csr_we),
      .wdata(csr_wdata), .pend(pend), .rdata(csr_rdata), .cfg(cfg), .ack(ack));

   assign irq_req    = pend & ~cfg.mask;
   assign pullup_dis = cfg.pudis;

   // R3
   edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> pend);
   // R4
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode && !pin_s) |=> pend);
   // R6
   clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fall && !(cfg.mode && !pin_s)) |=> !pend);
   // R11
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !fall && !(cfg.mode && !pin_s)) |=> !pend);
endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_n = 1'b1;
   logic       csr_sel = 1'b0;
   logic       csr_we = 1'b0;
   logic [7:0] csr_wdata = 8'h00;
   logic [7:0] csr_rdata;
   logic       vec_fetch = 1'b0;
   logic       irq_req;
   logic       pullup_dis;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   extint_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .csr_sel(csr_sel),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .vec_fetch(vec_fetch), .irq_req(irq_req), .pullup_dis(pullup_dis));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      csr_sel = 1'b1; csr_we = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_sel = 1'b0; csr_we = 1'b0; csr_wdata = 8'h00;
   endtask

   task automatic rd(output logic [7:0] d);
      csr_sel = 1'b1; csr_we = 1'b0;
      #1 d = csr_rdata;
      csr_sel = 1'b0;
   endtask

   task automatic vec_pulse();
      vec_fetch = 1'b1;
      @(negedge clk);
      vec_fetch = 1'b0;
   endtask

   task automatic pin_high_settle();
      pin_n = 1'b1; cyc(3);
   endtask

   task automatic t_reset();
      logic [7:0] r;
      rd(r);
      check("R1 reg", r, 8'h00);
      check("R1 irq", {7'd0, irq_req}, 8'h00);
      check("R1 pullup", {7'd0, pullup_dis}, 8'h00);
   endtask

   task automatic t_layout();
      logic [7:0] r;
      wr(8'hFF);
      rd(r);
      check("R2 R7 all-ones write", r, 8'h23);
      wr(8'h00);
      rd(r);
      check("R2 cleared", r, 8'h00);
   endtask

   task automatic t_pullup_unsel();
      logic [7:0] r;
      wr(8'h20);
      #1 check("R12 unselected rdata", csr_rdata, 8'h00);
      check("R10 pullup on", {7'd0, pullup_dis}, 8'h01);
      wr(8'h00);
      check("R10 pullup off", {7'd0, pullup_dis}, 8'h00);
   endtask

   task automatic t_edge();
      logic [7:0] r;
      pin_n = 1'b0;
      cyc(2); rd(r);
      check("R3 not yet pending", r, 8'h00);
      cyc(1); rd(r);
      check("R3 pending after edge", r, 8'h08);
      check("R5 irq unmasked", {7'd0, irq_req}, 8'h01);
      wr(8'h04);
      rd(r);
      check("R6 ack clears", r, 8'h00);
      cyc(4); rd(r);
      check("R3 held low no reset", r, 8'h00);
      pin_high_settle();
      cyc(2); rd(r);
      check("R11 rising edge ignored", r, 8'h00);
   endtask

   task automatic t_ack_zero();
      logic [7:0] r;
      pin_n = 1'b0; cyc(3);
      wr(8'h00);
      rd(r);
      check("R6 ack bit 0 no effect", r, 8'h08);
      wr(8'h04);
      rd(r);
      check("R6 ack bit 1 clears", r, 8'h00);
      pin_high_settle();
   endtask

   task automatic t_mask();
      logic [7:0] r;
      wr(8'h02);
      pin_n = 1'b0; cyc(3);
      rd(r);
      check("R5 masked pending visible", r, 8'h0A);
      check("R5 masked irq low", {7'd0, irq_req}, 8'h00);
      wr(8'h00);
      check("R5 unmask irq high", {7'd0, irq_req}, 8'h01);
      wr(8'h04);
      pin_high_settle();
   endtask

   task automatic t_level();
      logic [7:0] r;
      wr(8'h01);
      pin_n = 1'b0; cyc(3);
      rd(r);
      check("R4 level pending", r, 8'h09);
      wr(8'h05);
      rd(r);
      check("R4 ack while low ignored", r, 8'h09);
      check("R4 irq persists", {7'd0, irq_req}, 8'h01);
      pin_high_settle();
      rd(r);
      check("R4 latched after release", r, 8'h09);
      wr(8'h05);
      rd(r);
      check("R4 ack after release", r, 8'h01);
      check("R4 irq dropped", {7'd0, irq_req}, 8'h00);
      wr(8'h00);
   endtask

   task automatic t_vec();
      logic [7:0] r;
      pin_n = 1'b0; cyc(3);
      vec_pulse();
      rd(r);
      check("R8 vector fetch clears", r, 8'h00);
      pin_high_settle();
   endtask

   task automatic t_race();
      logic [7:0] r;
      pin_n = 1'b0; cyc(3);
      pin_high_settle();
      pin_n = 1'b0; cyc(2);
      wr(8'h04);
      rd(r);
      check("R9 edge beats ack", r, 8'h08);
      wr(8'h04);
      pin_high_settle();
      pin_n = 1'b0; cyc(2);
      vec_pulse();
      rd(r);
      check("R9 edge beats vector fetch", r, 8'h08);
      wr(8'h04);
      rd(r);
      check("R6 final clear", r, 8'h00);
      pin_high_settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_layout();
      t_pullup_unsel();
      t_edge();
      t_ack_zero();
      t_mask();
      t_level();
      t_vec();
      t_race();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule